// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges six reset requests into one registered system reset for a small microcontroller-style core. The requests are an active-low external reset pin, a watchdog overflow pulse, a power-on-clear "supply below threshold" level, a low-voltage-detector level, an illegal-opcode strobe from the instruction decoder, and a reset-processing check-error strobe. The sources release in different ways:
- The pin releases when it returns high.
- The three one-cycle strobes release by themselves.
- The two supply-monitor sources hold until a supply-good input confirms the supply has recovered.

The asynchronous levels pass through a two-stage synchronizer. The external pin also passes through a low-width filter, so that short glitches do not reset the chip. Any request asserts the system reset on the next clock edge. Release waits until a parameterized number of consecutive request-free cycles has passed. When the reset releases, the block presents a two-cycle fetch of the restart vector at word addresses 0 and 1.

While reset is active, every oscillator enable is forced off and the external clock input is flagged unusable. One chosen pad is driven low and every other pad is released to high impedance. A sticky cause register keeps one bit per source. A power-on-clear event wipes all other bits, and software can clear bits by writing ones.

Top module: `rst_hub`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1, `cause` is 0, every bit of `osc_en` is 0 and `ext_clk_ok` is 0. After `rst_n` rises with no request pending, `sys_rst` falls on the STAB_CYC-th clock edge.
- R2: A low level on `ext_rst_n` lasting at least PIN_MIN_CYC clock cycles raises `sys_rst`; the rise is seen PIN_MIN_CYC+3 edges after the pin falls. A low level of PIN_MIN_CYC-1 cycles or fewer never raises `sys_rst`.
- R3: A pin reset holds as long as the pin stays low. After the pin returns high, `sys_rst` falls STAB_CYC+3 edges later.
- R4: A one-cycle `wdt_ovf` pulse raises `sys_rst` on the second edge after it is driven. The reset releases by itself, STAB_CYC+2 edges after the pulse.
- R5: `poc_low` or `lvd_low` raises `sys_rst` on the third edge. Reset stays asserted after the level clears for as long as `supply_ok` is 0. It falls STAB_CYC+3 edges after `supply_ok` rises.
- R6: `opc_valid` with `opc` equal to ILL_OPC (0xFF at 8 bits) and `dbg_mode` low raises `sys_rst` with the same timing as R4. Any other opcode, or `dbg_mode` high, leaves `sys_rst` at 0.
- R7: A one-cycle `chk_err` pulse behaves like R4.
- R8: On the first cycle with `sys_rst` low after a release, `vec_rd` is 1 and `vec_addr` is 0x0000. On the next cycle `vec_addr` is 0x0001. After that, `vec_rd` is 0.
- R9: `osc_en` is all zeros and `ext_clk_ok` is 0 whenever `sys_rst` is 1. Both are all ones when `sys_rst` is 0.
- R10: While `sys_rst` is 1, `pad_drive_low` has only bit KEEP_LOW_IDX set and `pad_hiz` has every other bit set. Both are 0 while `sys_rst` is 0.
- R11: `cause` bit positions are: pin 0, watchdog 1, power-on-clear 2, low-voltage 3, illegal opcode 4, check error 5. A bit is set on the same edge that raises `sys_rst` for its source, and it stays set.
- R12: A power-on-clear request leaves `cause` equal to 0x04. A `cause_clr_we` cycle clears the bits that are 1 in `cause_clr_mask`. A source that is setting a bit in the same cycle wins over the clear.
- R13: `sys_rst` falls only after STAB_CYC consecutive cycles with no request. A new request during that count restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low initialization of the block's own state |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow pulse, synchronous |
| poc_low | input | 1 | Power-on-clear: supply below threshold, asynchronous level |
| lvd_low | input | 1 | Low-voltage detector tripped, asynchronous level |
| supply_ok | input | 1 | Supply at or above detection level, asynchronous level |
| opc_valid | input | 1 | Decoder is executing `opc` this cycle |
| opc | input | OPC_W | Opcode being executed |
| dbg_mode | input | 1 | Debug mode; suppresses the illegal-opcode reset |
| chk_err | input | 1 | Reset-processing check-error strobe |
| cause_clr_we | input | 1 | Write-one-to-clear strobe for `cause` |
| cause_clr_mask | input | 6 | Bits of `cause` to clear |
| sys_rst | output | 1 | Registered system reset, active high |
| osc_en | output | NOSC | Oscillator enables, all low in reset |
| ext_clk_ok | output | 1 | External clock input usable |
| pad_hiz | output | NPORT | Per-pad high-impedance control |
| pad_drive_low | output | NPORT | Per-pad force-low control |
| cause | output | 6 | Sticky reset-cause bits |
| vec_rd | output | 1 | Restart vector fetch in progress |
| vec_addr | output | AW | Restart vector fetch address |

## Verification
The bench builds the block with PIN_MIN_CYC=4, STAB_CYC=3, NPORT=4, KEEP_LOW_IDX=2 and NOSC=3. With these values the external low width can be swept from one cycle to two past the acceptance threshold, and each release can be timed exactly to the edge. The short stabilization count makes it practical to walk all 256 opcodes under both debug settings, each followed by a full reset and release. Every cause bit is set and then cleared one position at a time. Clear-versus-set collisions and the power-on-clear wipe are also exercised.

// File: rtl/rst_hub_pkg.sv
// Shared constants for the reset controller: source count, the bit
// position of each source in the cause register, and the vector-fetch states.
package rst_hub_pkg;
    localparam int NSRC    = 6;
    localparam int SRC_PIN = 0;
    localparam int SRC_WDT = 1;
    localparam int SRC_POC = 2;
    localparam int SRC_LVD = 3;
    localparam int SRC_ILL = 4;
    localparam int SRC_CHK = 5;

    typedef enum logic [1:0] {
        VEC_IDLE = 2'd0,
        VEC_LO   = 2'd1,
        VEC_HI   = 2'd2
    } vec_state_e;
endpackage

// File: rtl/rst_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous levels.
// Assumes each bit is independent (no bus coherency is needed). On rst_n,
// every stage takes the per-bit INIT value so that idle levels read inactive.
module rst_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the sampled inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_pin_filter.sv
// Low-width qualifier for the synchronized external reset pin.
// Raises req once the pin has read low for MIN_CYC consecutive samples.
// Holds req while the pin stays low, and drops it on the first high sample.
module rst_pin_filter #(
    parameter int MIN_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_s,
    output logic req
);
    localparam int CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;

    logic [CW-1:0] cnt;

    // Count low samples; qualify at the threshold; any high sample resets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (pin_n_s) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (cnt == CW'(MIN_CYC - 1)) begin
            req <= 1'b1;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rst_seq.sv
// Reset sequencer. Asserts sys_rst on the edge after any request.
// Releases only after STAB_CYC request-free cycles, then steps the
// restart-vector fetch through word 0 and word 1.
// Assumes STAB_CYC >= 1.
module rst_seq import rst_hub_pkg::*; #(
    parameter int STAB_CYC = 64,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    output logic          sys_rst,
    output logic          vec_rd,
    output logic [AW-1:0] vec_addr
);
    localparam int SW = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;

    logic [SW-1:0] stab_cnt;
    vec_state_e    vst;

    // Assert on request, count quiet cycles, release, then run the vector fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst  <= 1'b1;
            stab_cnt <= '0;
            vst      <= VEC_IDLE;
        end else if (any_req) begin
            sys_rst  <= 1'b1;
            stab_cnt <= '0;
            vst      <= VEC_IDLE;
        end else if (sys_rst) begin
            if (stab_cnt == SW'(STAB_CYC - 1)) begin
                sys_rst  <= 1'b0;
                stab_cnt <= '0;
                vst      <= VEC_LO;
            end else begin
                stab_cnt <= stab_cnt + SW'(1);
            end
        end else begin
            case (vst)
                VEC_LO:  vst <= VEC_HI;
                default: vst <= VEC_IDLE;
            endcase
        end
    end

    assign vec_rd   = (vst != VEC_IDLE);
    assign vec_addr = (vst == VEC_HI) ? AW'(1) : '0;
endmodule

// File: rtl/rst_cause.sv
// Sticky reset-cause register with one bit per source.
// A power-on-clear wipes every other bit. Otherwise, a software clear
// strobe removes masked bits, and sources setting a bit win over the clear.
module rst_cause import rst_hub_pkg::*; (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic            poc_now,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] cause
);
    localparam logic [NSRC-1:0] POC_ONLY = NSRC'(1) << SRC_POC;

    // Update cause bits: power-on-clear first, then clear-with-set, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (poc_now) begin
            cause <= POC_ONLY;
        end else if (clr_we) begin
            cause <= (cause & ~clr_mask) | set_vec;
        end else begin
            cause <= cause | set_vec;
        end
    end
endmodule

// File: rtl/rst_hub.sv
// Multi-source system reset controller (top).
// Synchronizes the asynchronous levels and qualifies the pin width.
// Registers the synchronous strobes and holds the supply-monitor resets
// until supply_ok. Merges everything into one registered reset with a
// quiet-time release, and drives the clock, pad and cause outputs.
// Assumes wdt_ovf, opc_valid/opc, dbg_mode, chk_err and the clear strobe
// are synchronous to clk.
module rst_hub import rst_hub_pkg::*; #(
    parameter int PIN_MIN_CYC = 400,
    parameter int STAB_CYC = 64,
    parameter int NPORT = 16,
    parameter int KEEP_LOW_IDX = 0,
    parameter int NOSC = 4,
    parameter int AW = 16,
    parameter int OPC_W = 8,
    parameter logic [OPC_W-1:0] ILL_OPC = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_n,
    input  logic             wdt_ovf,
    input  logic             poc_low,
    input  logic             lvd_low,
    input  logic             supply_ok,
    input  logic             opc_valid,
    input  logic [OPC_W-1:0] opc,
    input  logic             dbg_mode,
    input  logic             chk_err,
    input  logic             cause_clr_we,
    input  logic [NSRC-1:0]  cause_clr_mask,
    output logic             sys_rst,
    output logic [NOSC-1:0]  osc_en,
    output logic             ext_clk_ok,
    output logic [NPORT-1:0] pad_hiz,
    output logic [NPORT-1:0] pad_drive_low,
    output logic [NSRC-1:0]  cause,
    output logic             vec_rd,
    output logic [AW-1:0]    vec_addr
);
    localparam int NASYNC = 4;

    logic [NASYNC-1:0] async_raw;
    logic [NASYNC-1:0] async_s;
    logic              ext_s, poc_s, lvd_s, sup_ok_s;
    logic              pin_req;
    logic              wdt_q, ill_q, chk_q;
    logic              poc_hold, lvd_hold;
    logic [NSRC-1:0]   src_vec;
    logic              any_req;

    assign async_raw = {supply_ok, lvd_low, poc_low, ext_rst_n};

    rst_sync #(.W(NASYNC), .STAGES(2), .INIT(4'b0001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_raw),
        .q     (async_s)
    );

    assign ext_s    = async_s[0];
    assign poc_s    = async_s[1];
    assign lvd_s    = async_s[2];
    assign sup_ok_s = async_s[3];

    rst_pin_filter #(.MIN_CYC(PIN_MIN_CYC)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_s (ext_s),
        .req     (pin_req)
    );

    // Register the synchronous strobes; qualify the illegal opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_q <= 1'b0;
            ill_q <= 1'b0;
            chk_q <= 1'b0;
        end else begin
            wdt_q <= wdt_ovf;
            ill_q <= opc_valid && (opc == ILL_OPC) && !dbg_mode;
            chk_q <= chk_err;
        end
    end

    // Hold the supply-monitor resets until the supply is confirmed good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poc_hold <= 1'b0;
            lvd_hold <= 1'b0;
        end else begin
            if (poc_s)         poc_hold <= 1'b1;
            else if (sup_ok_s) poc_hold <= 1'b0;
            if (lvd_s)         lvd_hold <= 1'b1;
            else if (sup_ok_s) lvd_hold <= 1'b0;
        end
    end

    assign src_vec[SRC_PIN] = pin_req;
    assign src_vec[SRC_WDT] = wdt_q;
    assign src_vec[SRC_POC] = poc_s | poc_hold;
    assign src_vec[SRC_LVD] = lvd_s | lvd_hold;
    assign src_vec[SRC_ILL] = ill_q;
    assign src_vec[SRC_CHK] = chk_q;
    assign any_req = |src_vec;

    rst_seq #(.STAB_CYC(STAB_CYC), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_req  (any_req),
        .sys_rst  (sys_rst),
        .vec_rd   (vec_rd),
        .vec_addr (vec_addr)
    );

    rst_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (src_vec),
        .poc_now  (poc_s),
        .clr_we   (cause_clr_we),
        .clr_mask (cause_clr_mask),
        .cause    (cause)
    );

    assign osc_en     = {NOSC{~sys_rst}};
    assign ext_clk_ok = ~sys_rst;

    // Per-pad reset behaviour: one pad forced low, the rest floated.
    for (genvar g = 0; g < NPORT; g++) begin : g_pad
        if (g == KEEP_LOW_IDX) begin : g_keep
            assign pad_drive_low[g] = sys_rst;
            assign pad_hiz[g]       = 1'b0;
        end else begin : g_float
            assign pad_drive_low[g] = 1'b0;
            assign pad_hiz[g]       = sys_rst;
        end
    end
endmodule

// File: rtl/rst_hub_chk.sv
// Assertion checker for rst_hub, attached by bind. Keeps a quiet-cycle
// counter of its own to check the release window.
module rst_hub_chk #(
    parameter int STAB_CYC = 64,
    parameter int NPORT = 16,
    parameter int NOSC = 4,
    parameter int AW = 16,
    parameter int OPC_W = 8,
    parameter logic [OPC_W-1:0] ILL_OPC = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_ovf,
    input logic             opc_valid,
    input logic [OPC_W-1:0] opc,
    input logic             dbg_mode,
    input logic             chk_err,
    input logic             cause_clr_we,
    input logic             poc_s,
    input logic             any_req,
    input logic             sys_rst,
    input logic [5:0]       cause,
    input logic             vec_rd,
    input logic [AW-1:0]    vec_addr,
    input logic [NOSC-1:0]  osc_en,
    input logic             ext_clk_ok,
    input logic [NPORT-1:0] pad_hiz,
    input logic [NPORT-1:0] pad_drive_low
);
    localparam int QW = $clog2(STAB_CYC + 1);

    logic [QW-1:0] qcnt;

    // Count request-free cycles, saturating at STAB_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                      qcnt <= '0;
        else if (any_req)                qcnt <= '0;
        else if (qcnt != QW'(STAB_CYC))  qcnt <= qcnt + QW'(1);
    end

    p_wdt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |-> ##2 sys_rst);

    p_ill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_valid && opc == ILL_OPC && !dbg_mode) |-> ##2 sys_rst);

    p_chk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |-> ##2 sys_rst);

    p_vec_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (vec_rd && vec_addr == '0));

    p_vec_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec_addr == '0 && !sys_rst) |=> (sys_rst || (vec_rd && vec_addr == AW'(1))));

    p_osc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (osc_en == '0 && !ext_clk_ok));

    p_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_drive_low) && ((pad_drive_low & pad_hiz) == '0));

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_clr_we && !poc_s) |=> ((cause & $past(cause)) == $past(cause)));

    p_poc_wipe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        poc_s |=> (cause == 6'b000100));

    p_stab_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (qcnt == QW'(STAB_CYC)));
endmodule

bind rst_hub rst_hub_chk #(
    .STAB_CYC (STAB_CYC),
    .NPORT    (NPORT),
    .NOSC     (NOSC),
    .AW       (AW),
    .OPC_W    (OPC_W),
    .ILL_OPC  (ILL_OPC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_ovf       (wdt_ovf),
    .opc_valid     (opc_valid),
    .opc           (opc),
    .dbg_mode      (dbg_mode),
    .chk_err       (chk_err),
    .cause_clr_we  (cause_clr_we),
    .poc_s         (poc_s),
    .any_req       (any_req),
    .sys_rst       (sys_rst),
    .cause         (cause),
    .vec_rd        (vec_rd),
    .vec_addr      (vec_addr),
    .osc_en        (osc_en),
    .ext_clk_ok    (ext_clk_ok),
    .pad_hiz       (pad_hiz),
    .pad_drive_low (pad_drive_low)
);

// File: tb/rst_hub_bench.sv
// Self-checking bench for rst_hub with a small configuration. Inputs change
// at the falling edge; outputs are sampled at the falling edge.
module rst_hub_bench;
    localparam int PIN_MIN = 4;
    localparam int STAB    = 3;
    localparam int NPORT   = 4;
    localparam int KEEP    = 2;
    localparam int NOSC    = 3;
    localparam int AW      = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, ext_rst_n, wdt_ovf, poc_low, lvd_low, supply_ok;
    logic             opc_valid, dbg_mode, chk_err, cause_clr_we;
    logic [7:0]       opc;
    logic [5:0]       cause_clr_mask;
    logic             sys_rst, ext_clk_ok, vec_rd;
    logic [NOSC-1:0]  osc_en;
    logic [NPORT-1:0] pad_hiz, pad_drive_low;
    logic [5:0]       cause;
    logic [AW-1:0]    vec_addr;

    rst_hub #(
        .PIN_MIN_CYC (PIN_MIN), .STAB_CYC (STAB), .NPORT (NPORT),
        .KEEP_LOW_IDX (KEEP), .NOSC (NOSC), .AW (AW), .OPC_W (8), .ILL_OPC (8'hFF)
    ) u_rst_hub (
        .clk (clk), .rst_n (rst_n), .ext_rst_n (ext_rst_n), .wdt_ovf (wdt_ovf),
        .poc_low (poc_low), .lvd_low (lvd_low), .supply_ok (supply_ok),
        .opc_valid (opc_valid), .opc (opc), .dbg_mode (dbg_mode), .chk_err (chk_err),
        .cause_clr_we (cause_clr_we), .cause_clr_mask (cause_clr_mask),
        .sys_rst (sys_rst), .osc_en (osc_en), .ext_clk_ok (ext_clk_ok),
        .pad_hiz (pad_hiz), .pad_drive_low (pad_drive_low), .cause (cause),
        .vec_rd (vec_rd), .vec_addr (vec_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [5:0] exp_cause;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_level(input logic lvl, input int start, output int n);
        n = start;
        while (sys_rst !== lvl && n < 1000) begin
            tick();
            n++;
        end
    endtask

    // which: 1 watchdog, 5 check error
    task automatic strobe(input int which);
        if (which == 1) wdt_ovf = 1'b1; else chk_err = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        chk_err = 1'b0;
    endtask

    task automatic chk_pins(input logic in_rst);
        chk("R9 osc_en", 32'(osc_en), in_rst ? 32'h0 : 32'((1 << NOSC) - 1));
        chk("R9 ext_clk_ok", 32'(ext_clk_ok), in_rst ? 32'h0 : 32'h1);
        chk("R10 pad_drive_low", 32'(pad_drive_low), in_rst ? 32'(1 << KEEP) : 32'h0);
        chk("R10 pad_hiz", 32'(pad_hiz),
            in_rst ? 32'(((1 << NPORT) - 1) & ~(1 << KEEP)) : 32'h0);
    endtask

    task automatic chk_vector();
        chk("R8 vec_rd first", 32'(vec_rd), 32'h1);
        chk("R8 vec_addr first", 32'(vec_addr), 32'h0);
        tick();
        chk("R8 vec_rd second", 32'(vec_rd), 32'h1);
        chk("R8 vec_addr second", 32'(vec_addr), 32'h1);
        tick();
        chk("R8 vec_rd done", 32'(vec_rd), 32'h0);
    endtask

    task automatic settle();
        int n;
        wait_level(1'b0, 0, n);
        ticks(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL all requirements: watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        logic seen;
        rst_n = 1'b0; ext_rst_n = 1'b1; wdt_ovf = 1'b0; poc_low = 1'b0; lvd_low = 1'b0;
        supply_ok = 1'b1; opc_valid = 1'b0; opc = 8'h00; dbg_mode = 1'b0; chk_err = 1'b0;
        cause_clr_we = 1'b0; cause_clr_mask = 6'h0;
        @(negedge clk);
        ticks(3);

        // R1 reset state
        chk("R1 sys_rst in init", 32'(sys_rst), 32'h1);
        chk("R1 cause in init", 32'(cause), 32'h0);
        chk_pins(1'b1);

        // R1 / R13 release after init
        rst_n = 1'b1;
        wait_level(1'b0, 0, n);
        chk("R1 R13 init release edges", 32'(n), 32'(STAB));
        chk_vector();
        chk_pins(1'b0);

        // R2 pin width sweep
        exp_cause = 6'h0;
        for (int w = 1; w <= PIN_MIN + 2; w++) begin
            ext_rst_n = 1'b0;
            ticks(w);
            ext_rst_n = 1'b1;
            seen = 1'b0;
            for (int i = 0; i < PIN_MIN + 6; i++) begin
                tick();
                if (sys_rst) seen = 1'b1;
            end
            chk($sformatf("R2 pin low width %0d", w), 32'(seen), 32'(w >= PIN_MIN));
            settle();
        end
        exp_cause[0] = 1'b1;
        chk("R11 cause pin bit", 32'(cause), 32'(exp_cause));

        // R2 / R3 held pin: exact rise, hold, exact release
        ext_rst_n = 1'b0;
        wait_level(1'b1, 0, n);
        chk("R2 pin rise edges", 32'(n), 32'(PIN_MIN + 3));
        ticks(30);
        chk("R3 pin held reset", 32'(sys_rst), 32'h1);
        chk_pins(1'b1);
        ext_rst_n = 1'b1;
        wait_level(1'b0, 0, n);
        chk("R3 pin release edges", 32'(n), 32'(STAB + 3));
        chk_vector();

        // R4 watchdog
        strobe(1);
        wait_level(1'b1, 1, n);
        chk("R4 wdt rise edges", 32'(n), 32'h2);
        exp_cause[1] = 1'b1;
        chk("R11 cause wdt bit", 32'(cause), 32'(exp_cause));
        wait_level(1'b0, n, n);
        chk("R4 wdt release edges", 32'(n), 32'(STAB + 2));
        chk_vector();

        // R7 check error
        strobe(5);
        wait_level(1'b1, 1, n);
        chk("R7 chk rise edges", 32'(n), 32'h2);
        exp_cause[5] = 1'b1;
        chk("R11 cause chk bit", 32'(cause), 32'(exp_cause));
        wait_level(1'b0, n, n);
        chk("R7 chk release edges", 32'(n), 32'(STAB + 2));
        ticks(3);

        // R13 restart of the quiet count
        strobe(1);
        tick();
        strobe(5);
        chk("R13 still in reset", 32'(sys_rst), 32'h1);
        wait_level(1'b0, 0, n);
        chk("R13 restart release edges", 32'(n), 32'(STAB + 1));
        ticks(3);

        // R6 opcode sweep, debug off and on
        for (int dbg = 0; dbg < 2; dbg++) begin
            for (int op = 0; op < 256; op++) begin
                opc_valid = 1'b1;
                opc = 8'(op);
                dbg_mode = dbg[0];
                tick();
                opc_valid = 1'b0;
                tick();
                chk($sformatf("R6 opcode %0h dbg %0d", op, dbg), 32'(sys_rst),
                    32'(op == 255 && dbg == 0));
                settle();
            end
        end
        dbg_mode = 1'b0;
        exp_cause[4] = 1'b1;
        chk("R11 cause illegal bit", 32'(cause), 32'(exp_cause));

        // R5 low-voltage
        supply_ok = 1'b0;
        lvd_low = 1'b1;
        wait_level(1'b1, 0, n);
        chk("R5 lvd rise edges", 32'(n), 32'h3);
        lvd_low = 1'b0;
        ticks(20);
        chk("R5 lvd held without supply_ok", 32'(sys_rst), 32'h1);
        supply_ok = 1'b1;
        wait_level(1'b0, 0, n);
        chk("R5 lvd release edges", 32'(n), 32'(STAB + 3));
        ticks(3);
        exp_cause[3] = 1'b1;
        chk("R11 cause accumulated", 32'(cause), 32'h3B);

        // R12 write-one-to-clear, one bit at a time
        cause_clr_we = 1'b1;
        cause_clr_mask = 6'h0;
        tick();
        cause_clr_we = 1'b0;
        chk("R12 empty mask keeps cause", 32'(cause), 32'(exp_cause));
        for (int b = 0; b < 6; b++) begin
            cause_clr_we = 1'b1;
            cause_clr_mask = 6'(1 << b);
            tick();
            cause_clr_we = 1'b0;
            exp_cause[b] = 1'b0;
            chk($sformatf("R12 clear bit %0d", b), 32'(cause), 32'(exp_cause));
        end

        // R12 set wins over clear in the same cycle
        wdt_ovf = 1'b1;
        tick();
        wdt_ovf = 1'b0;
        cause_clr_we = 1'b1;
        cause_clr_mask = 6'h02;
        tick();
        cause_clr_we = 1'b0;
        chk("R12 set wins over clear", 32'(cause), 32'h02);
        settle();

        // R5 / R12 power-on-clear
        supply_ok = 1'b0;
        poc_low = 1'b1;
        wait_level(1'b1, 0, n);
        chk("R5 poc rise edges", 32'(n), 32'h3);
        chk("R12 poc wipes cause", 32'(cause), 32'h04);
        poc_low = 1'b0;
        ticks(20);
        chk("R5 poc held without supply_ok", 32'(sys_rst), 32'h1);
        supply_ok = 1'b1;
        wait_level(1'b0, 0, n);
        chk("R5 poc release edges", 32'(n), 32'(STAB + 3));
        chk_vector();
        chk_pins(1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule